// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Link with Held Receive Byte

This block moves one byte at a time over a four-wire synchronous serial bus, as either the bus master or a bus slave. Software sees a single data location. A write offers the next byte to send and goes straight into the shift register. The byte that arrived last sits in a holding register that reads return. The holding register is separate from the shifter, so software can read the previous result at any time until the next byte is complete.

As master, the block makes the serial clock from the system clock and drives the select line low for exactly one byte. As slave, it synchronises the external select, clock and data lines into the system clock domain. It shifts only while select is low. Clock idle level and sampling phase can be changed between transfers. A completion flag and a collision flag report status.

The transmit side is a valid/ready interface with no queue. `tx_ready` is high only while the block is enabled and no byte is being shifted. A byte offered while `tx_ready` is low is never held back for a later cycle. It is discarded and recorded as a collision. Each pin has separate input, output and output-enable signals, and pin direction follows the selected role.

Top module: `spi_duplex_port`

## Requirements
- R1: In master mode, a byte accepted on tx_valid/tx_ready goes out on mosi_out most significant bit first. The eight bits taken from miso_in, first bit most significant, appear on rx_data once the byte is complete.
- R2: The idle level of sck_out equals cpol. The leading edge is the edge that leaves the idle level. With cpha=0, data is sampled on leading edges and changes on trailing edges, and the first bit is valid before the first edge. With cpha=1, data changes on leading edges and is sampled on trailing edges.
- R3: In master mode every SCK half period lasts sck_div+1 system clocks, and one byte uses exactly 16 SCK edges.
- R4: In master mode ss_n_out goes low on the clock after a byte is accepted. It stays low through all 16 edges and returns high one half period after the last edge. It is high while idle.
- R5: In slave mode, the byte written earlier goes out on miso_out while the external master clocks in mosi_in. After eight sample edges, the byte received from mosi_in appears on rx_data.
- R6: In slave mode, while ss_n_in is high, miso_oe is low and any partial bit count is discarded. A transfer cut short raises no completion, and the next full transfer is received correctly.
- R7: done_flag is set when a completed byte is copied to rx_data. A rx_rd pulse clears it. If both happen in the same cycle, the set wins.
- R8: rx_data changes only when a byte completes. Reads, writes and an ongoing transfer leave it unchanged.
- R9: A write offered while a byte is being shifted (tx_valid=1, tx_ready=0, enabled) is dropped: the byte in flight is unaffected. wcol_flag is set, and the next accepted write clears it.
- R10: tx_ready is high only when the block is enabled and idle. In master mode idle means no transfer is running. In slave mode it means the synchronised ss_n_in is high.
- R11: With enable=0, every output enable is low and tx_ready is low. Offered bytes start nothing and set no flag.
- R12: In master mode ss_n_oe, sck_oe and mosi_oe are high and miso_oe is low. In slave mode those three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; when low, all pins are released |
| master_mode | input | 1 | 1 = master role, 0 = slave role |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| sck_div | input | DIV_W | SCK half period in system clocks, minus one |
| tx_valid | input | 1 | A byte to transmit is offered |
| tx_ready | output | 1 | The offered byte is taken this cycle |
| tx_data | input | DW | Byte to transmit |
| rx_rd | input | 1 | Read strobe for the data location; clears done_flag |
| rx_data | output | DW | Last completed received byte |
| done_flag | output | 1 | A byte has completed since the last read |
| wcol_flag | output | 1 | A write was dropped because a transfer was running |
| ss_n_in | input | 1 | Select pin input (slave role) |
| ss_n_out | output | 1 | Select pin output (master role) |
| ss_n_oe | output | 1 | Select pin output enable |
| sck_in | input | 1 | Serial clock pin input (slave role) |
| sck_out | output | 1 | Serial clock pin output (master role) |
| sck_oe | output | 1 | Serial clock pin output enable |
| mosi_in | input | 1 | Master-to-slave data input (slave role) |
| mosi_out | output | 1 | Master-to-slave data output (master role) |
| mosi_oe | output | 1 | Master-to-slave data output enable |
| miso_in | input | 1 | Slave-to-master data input (master role) |
| miso_out | output | 1 | Slave-to-master data output (slave role) |
| miso_oe | output | 1 | Slave-to-master data output enable |

## Verification
A bit counter that is off by one, or that is not cleared when select rises, shows up as a byte shifted by one position on rx_data. It can also show up as a missing or early done_flag, visible by the end of the affected byte. If the sample and shift edges are swapped for one clock format, the bit received first and the bit sent last are both corrupted, so every random byte in that format fails within one transfer. A stuck busy or flag state shows at once as tx_ready or wcol_flag disagreeing with the expected value on the next offered write.

// File: rtl/spi_pkg.sv
package spi_pkg;
  typedef enum logic {ROLE_SLAVE = 1'b0, ROLE_MASTER = 1'b1} role_e;

  // one-cycle strobes marking an SCK edge, classified against the idle level
  typedef struct packed {
    logic lead;
    logic trail;
  } sck_edge_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] init,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= init;
        else        pipe <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= {STAGES{init}};
        else        pipe <= {pipe[STAGES-2:0], d};
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import spi_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             cpol,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             active,
  output sck_edge_t        edge_o
);
  localparam int EDGES = 2 * DW;
  localparam int EW    = $clog2(EDGES + 1);

  logic [DIV_W-1:0] hc;
  logic [EW-1:0]    ecnt;
  logic             sck_q;
  logic             term;

  assign term = (hc >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      hc     <= '0;
      ecnt   <= '0;
      sck_q  <= 1'b0;
      edge_o <= '0;
    end else begin
      edge_o <= '0;
      if (stop) begin
        active <= 1'b0;
      end else if (start) begin
        active <= 1'b1;
        hc     <= '0;
        ecnt   <= '0;
        sck_q  <= cpol;
      end else if (active) begin
        if (term) begin
          hc <= '0;
          if (ecnt == EW'(EDGES)) begin
            active <= 1'b0;          // trailing half period of select hold
          end else begin
            sck_q        <= ~sck_q;
            ecnt         <= ecnt + 1'b1;
            edge_o.lead  <= ~ecnt[0];
            edge_o.trail <= ecnt[0];
          end
        end else begin
          hc <= hc + 1'b1;
        end
      end
    end
  end

  assign sck = active ? sck_q : cpol;
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  sck_edge_t     ev,
  input  logic          cpha,
  input  logic          sin,
  output logic          sout,
  output logic          done,
  output logic [DW-1:0] rx_word
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0] txsh;
  logic [DW-1:0] rxsh;
  logic          out_q;
  logic [CW-1:0] cnt;
  logic          smp;
  logic          shf;
  logic [DW-1:0] rx_next;

  assign smp     = cpha ? ev.trail : ev.lead;
  assign shf     = cpha ? ev.lead  : ev.trail;
  assign rx_next = {rxsh[DW-2:0], sin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txsh    <= '0;
      rxsh    <= '0;
      out_q   <= 1'b0;
      cnt     <= '0;
      done    <= 1'b0;
      rx_word <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        txsh  <= load_data;
        out_q <= load_data[DW-1];
      end else if (shf) begin
        out_q <= txsh[DW-1];
        txsh  <= {txsh[DW-2:0], 1'b0};
      end
      if (clear || load) begin
        cnt <= '0;
      end else if (smp) begin
        rxsh <= rx_next;
        if (cnt == CW'(DW - 1)) begin
          cnt     <= '0;
          done    <= 1'b1;
          rx_word <= rx_next;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // phase 0 presents the head bit before any edge, phase 1 after the leading edge
  assign sout = cpha ? out_q : txsh[DW-1];
endmodule

// File: rtl/spi_duplex_port.sv
module spi_duplex_port
  import spi_pkg::*;
#(
  parameter int DW          = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             master_mode,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIV_W-1:0] sck_div,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [DW-1:0]    tx_data,
  input  logic             rx_rd,
  output logic [DW-1:0]    rx_data,
  output logic             done_flag,
  output logic             wcol_flag,
  input  logic             ss_n_in,
  output logic             ss_n_out,
  output logic             ss_n_oe,
  input  logic             sck_in,
  output logic             sck_out,
  output logic             sck_oe,
  input  logic             mosi_in,
  output logic             mosi_out,
  output logic             mosi_oe,
  input  logic             miso_in,
  output logic             miso_out,
  output logic             miso_oe
);
  localparam int NSYNC = 3;

  role_e         role;
  logic          is_master;
  logic [NSYNC-1:0] pins_s;
  logic          ss_s, sck_s, mosi_s;
  logic          sck_prev;
  logic          sck_chg;
  sck_edge_t     slv_ev, gen_ev, core_ev;
  logic          gen_sck, gen_active;
  logic          busy, tx_fire, tx_coll;
  logic          core_clear, core_sin, core_sout, core_done;
  logic [DW-1:0] core_word;

  assign role      = role_e'(master_mode);
  assign is_master = (role == ROLE_MASTER);

  spi_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .init (3'b100),
    .d    ({ss_n_in, sck_in, mosi_in}),
    .q    (pins_s)
  );
  assign {ss_s, sck_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_s;

  assign sck_chg = enable && !is_master && !ss_s && (sck_s != sck_prev);

  always_comb begin
    slv_ev.lead  = sck_chg && (sck_s != cpol);
    slv_ev.trail = sck_chg && (sck_s == cpol);
  end

  // transmit handshake: no queue, a refused byte is a collision
  assign busy     = is_master ? gen_active : !ss_s;
  assign tx_ready = enable && !busy;
  assign tx_fire  = tx_valid && tx_ready;
  assign tx_coll  = tx_valid && enable && busy;

  spi_sck_gen #(.DW(DW), .DIV_W(DIV_W)) u_gen (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tx_fire && is_master),
    .stop  (!enable || !is_master),
    .cpol  (cpol),
    .div   (sck_div),
    .sck   (gen_sck),
    .active(gen_active),
    .edge_o(gen_ev)
  );

  assign core_ev    = is_master ? gen_ev : slv_ev;
  assign core_sin   = is_master ? miso_in : mosi_s;
  assign core_clear = !enable || (!is_master && ss_s);

  spi_shift_core #(.DW(DW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (core_clear),
    .load     (tx_fire),
    .load_data(tx_data),
    .ev       (core_ev),
    .cpha     (cpha),
    .sin      (core_sin),
    .sout     (core_sout),
    .done     (core_done),
    .rx_word  (core_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      done_flag <= 1'b0;
      wcol_flag <= 1'b0;
    end else begin
      if (core_done) begin
        rx_data   <= core_word;
        done_flag <= 1'b1;
      end else if (rx_rd) begin
        done_flag <= 1'b0;
      end
      if (tx_coll)      wcol_flag <= 1'b1;
      else if (tx_fire) wcol_flag <= 1'b0;
    end
  end

  assign ss_n_out = !gen_active;
  assign ss_n_oe  = enable && is_master;
  assign sck_out  = gen_sck;
  assign sck_oe   = enable && is_master;
  assign mosi_out = core_sout;
  assign mosi_oe  = enable && is_master;
  assign miso_out = core_sout;
  assign miso_oe  = enable && !is_master && !ss_s;
endmodule

// File: rtl/spi_duplex_port_chk.sv
module spi_duplex_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          master_mode,
  input logic          cpol,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] rx_data,
  input logic          done_flag,
  input logic          wcol_flag,
  input logic          ss_n_out,
  input logic          sck_out,
  input logic          miso_oe
);
  // R2: idle master clock rests at the polarity level
  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode && enable && ss_n_out |-> sck_out == cpol);

  // R4: every clock movement of a master happens under an asserted select
  p_ss_covers_sck_r4: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode && enable && $past(master_mode && enable) && $stable(cpol)
      && !$stable(sck_out) |-> !ss_n_out);

  // R4: select falls only right after an accepted byte
  p_ss_fall_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode && enable && $fell(ss_n_out) |-> $past(tx_valid && tx_ready));

  // R8: the held byte changes only together with a completion
  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> done_flag);

  // R9: a refused write is recorded
  p_wcol_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    enable && tx_valid && !tx_ready |=> wcol_flag);

  // R12: the slave data output is driven only in the slave role
  p_miso_role_r12: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> enable && !master_mode);
endmodule

bind spi_duplex_port spi_duplex_port_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .master_mode(master_mode),
  .cpol       (cpol),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .rx_data    (rx_data),
  .done_flag  (done_flag),
  .wcol_flag  (wcol_flag),
  .ss_n_out   (ss_n_out),
  .sck_out    (sck_out),
  .miso_oe    (miso_oe)
);

// File: tb/tb_spi_duplex_port.sv
`timescale 1ns/1ps
module tb_spi_duplex_port;
  localparam int DW = 8;
  localparam int DIV_W = 8;
  localparam int HS = 8;   // slave-side half period driven by the bench

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, master_mode = 1'b1, cpol = 1'b0, cpha = 1'b0;
  logic [DIV_W-1:0] sck_div = '0;
  logic tx_valid = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic rx_rd = 1'b0;
  logic ss_n_in = 1'b1, sck_in = 1'b0, mosi_in = 1'b0, miso_in = 1'b0;
  logic tx_ready, done_flag, wcol_flag;
  logic [DW-1:0] rx_data;
  logic ss_n_out, ss_n_oe, sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] last_rx = '0;

  always #4 clk = ~clk;

  spi_duplex_port #(.DW(DW), .DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .master_mode(master_mode),
    .cpol(cpol), .cpha(cpha), .sck_div(sck_div),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_rd(rx_rd), .rx_data(rx_data), .done_flag(done_flag), .wcol_flag(wcol_flag),
    .ss_n_in(ss_n_in), .ss_n_out(ss_n_out), .ss_n_oe(ss_n_oe),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
    .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
    .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_sample_edge(input logic lead, input logic ph);
    return lead ^ ph;
  endfunction

  task automatic read_rx(input logic [DW-1:0] exp);
    @(negedge clk);
    chk("R7 flag before read", done_flag, 1);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    chk("R7 flag cleared by read", done_flag, 0);
    chk("R8 read leaves rx_data", rx_data, exp);
  endtask

  task automatic run_master(input logic [DW-1:0] tb_byte, input logic [DW-1:0] sl_byte,
                            input logic p, input logic ph, input int dv,
                            input bit coll, input logic [DW-1:0] coll_byte);
    logic [DW-1:0] got = '0;
    int nedge = 0, hp = 0, idx = 0, bad_hp = 0, bad_ss = 0, guard = 0, cst = 0;
    logic prev;
    @(negedge clk);
    cpol = p; cpha = ph; sck_div = DIV_W'(dv); miso_in = sl_byte[DW-1];
    @(negedge clk);
    chk("R10 ready when idle", tx_ready, 1);
    chk("R2 idle level", sck_out, p);
    chk("R4 select high when idle", ss_n_out, 1);
    tx_valid = 1'b1; tx_data = tb_byte;
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R4 select low after accept", ss_n_out, 0);
    chk("R9 accepted write clears collision", wcol_flag, 0);
    chk("R12 master pin enables", {ss_n_oe, sck_oe, mosi_oe, miso_oe}, 4'b1110);
    prev = sck_out;
    while (ss_n_out == 1'b0 && guard < 5000) begin
      @(negedge clk);
      guard++; hp++;
      if (cst == 2) begin
        tx_valid = 1'b0;
        chk("R9 collision flagged", wcol_flag, 1);
        cst = 3;
      end
      if (coll && cst == 0 && nedge == 5) begin
        chk("R10 ready low while shifting", tx_ready, 0);
        tx_valid = 1'b1; tx_data = coll_byte;
        cst = 2;
      end
      if (nedge == 8 && hp == 1) chk("R8 rx_data held mid transfer", rx_data, last_rx);
      if (sck_out !== prev) begin
        if (hp != dv + 1) bad_hp++;
        if (ss_n_out) bad_ss++;
        if (is_sample_edge(sck_out != p, ph)) begin
          got = {got[DW-2:0], mosi_out};
          idx++;
        end else if (idx < DW) begin
          miso_in = sl_byte[DW-1-idx];
        end
        prev = sck_out; nedge++; hp = 0;
      end
    end
    chk("R4 select hold after last edge", hp, dv + 1);
    chk("R3 edge count", nedge, 16);
    chk("R3 half period length", bad_hp, 0);
    chk("R4 select low across edges", bad_ss, 0);
    chk(coll ? "R9 byte in flight untouched" : "R1 mosi byte", got, tb_byte);
    chk("R2 idle level after transfer", sck_out, p);
    @(negedge clk);
    chk("R1 received byte", rx_data, sl_byte);
    last_rx = sl_byte;
    read_rx(sl_byte);
  endtask

  task automatic slave_wait();
    repeat (HS) @(negedge clk);
  endtask

  task automatic run_slave(input logic [DW-1:0] dut_byte, input logic [DW-1:0] m_byte,
                           input logic p, input logic ph);
    logic [DW-1:0] got = '0;
    @(negedge clk);
    cpol = p; cpha = ph; sck_in = p;
    slave_wait();
    chk("R10 slave ready while deselected", tx_ready, 1);
    tx_valid = 1'b1; tx_data = dut_byte;
    @(negedge clk);
    tx_valid = 1'b0;
    mosi_in = ph ? 1'b0 : m_byte[DW-1];
    ss_n_in = 1'b0;
    slave_wait();
    chk("R12 slave output enabled under select", miso_oe, 1);
    chk("R10 slave ready low under select", tx_ready, 0);
    for (int i = 0; i < DW; i++) begin
      sck_in = ~p;
      if (ph) mosi_in = m_byte[DW-1-i];
      else    got = {got[DW-2:0], miso_out};
      slave_wait();
      if (i == 4) chk("R8 rx_data held during slave transfer", rx_data, last_rx);
      sck_in = p;
      if (ph) got = {got[DW-2:0], miso_out};
      else if (i < DW - 1) mosi_in = m_byte[DW-2-i];
      slave_wait();
    end
    ss_n_in = 1'b1;
    slave_wait();
    chk("R6 output released when deselected", miso_oe, 0);
    chk("R5 miso byte", got, dut_byte);
    chk("R5 received byte", rx_data, m_byte);
    last_rx = m_byte;
    read_rx(m_byte);
  endtask

  task automatic slave_partial(input logic p, input logic ph, input int nbits);
    @(negedge clk);
    cpol = p; cpha = ph; sck_in = p; mosi_in = 1'b1;
    ss_n_in = 1'b0;
    slave_wait();
    for (int i = 0; i < nbits; i++) begin
      sck_in = ~p; slave_wait();
      sck_in = p;  slave_wait();
    end
    ss_n_in = 1'b1;
    slave_wait();
    chk("R6 cut transfer raises no completion", done_flag, 0);
    chk("R6 cut transfer leaves rx_data", rx_data, last_rx);
    chk("R6 output released", miso_oe, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    chk("R7 reset done_flag", done_flag, 0);
    chk("R9 reset wcol_flag", wcol_flag, 0);
    chk("R8 reset rx_data", rx_data, 0);
    chk("R11 reset enables", {ss_n_oe, sck_oe, mosi_oe, miso_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: disabled block ignores writes
    tx_valid = 1'b1; tx_data = 8'h77;
    @(negedge clk);
    chk("R11 not ready when disabled", tx_ready, 0);
    tx_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 no select when disabled", ss_n_out, 1);
    chk("R11 no collision when disabled", wcol_flag, 0);
    chk("R11 enables low", {ss_n_oe, sck_oe, mosi_oe, miso_oe}, 0);

    enable = 1'b1; master_mode = 1'b1;
    // R1 R2 R3: directed corners across all four formats, smallest divisor first
    run_master(8'hA5, 8'h3C, 1'b0, 1'b0, 0, 1'b0, '0);
    run_master(8'h80, 8'h01, 1'b0, 1'b1, 1, 1'b0, '0);
    run_master(8'h01, 8'hFE, 1'b1, 1'b0, 2, 1'b0, '0);
    run_master(8'hFF, 8'h00, 1'b1, 1'b1, 0, 1'b0, '0);
    // R9: collision in the middle of a byte
    run_master(8'h5A, 8'hC3, 1'b0, 1'b1, 3, 1'b1, 8'h00);
    run_master(8'h96, 8'h69, 1'b1, 1'b0, 1, 1'b1, 8'hFF);
    for (int k = 0; k < 12; k++) begin
      run_master(DW'($urandom), DW'($urandom), 1'($urandom), 1'($urandom),
                 int'($urandom_range(0, 4)), 1'($urandom_range(0, 3) == 0), DW'($urandom));
    end

    @(negedge clk);
    master_mode = 1'b0;
    @(negedge clk);
    chk("R12 slave pin enables", {ss_n_oe, sck_oe, mosi_oe, miso_oe}, 4'b0000);
    run_slave(8'hC5, 8'h3A, 1'b0, 1'b0);
    run_slave(8'h81, 8'h7E, 1'b0, 1'b1);
    run_slave(8'h0F, 8'hF0, 1'b1, 1'b0);
    run_slave(8'h33, 8'hCC, 1'b1, 1'b1);
    slave_partial(1'b0, 1'b0, 3);
    run_slave(8'hE7, 8'h18, 1'b0, 1'b0);
    slave_partial(1'b1, 1'b1, 5);
    run_slave(8'h42, 8'hBD, 1'b1, 1'b1);
    for (int k = 0; k < 8; k++) begin
      run_slave(DW'($urandom), DW'($urandom), 1'($urandom), 1'($urandom));
    end

    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R11 enables low after disable", {ss_n_oe, sck_oe, mosi_oe, miso_oe}, 0);
    chk("R11 rx_data kept", rx_data, last_rx);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule